// File: doc/BRIEF.md
# Set/Clear Masked Interrupt Controller

This block gathers a parameterised number of active-high interrupt sources and gates each one with its own enable bit. Any source whose enable bit is 1 pulls a single active-low interrupt line to the processor low. The processor sees four word locations through a small register port made of an address, a write strobe, write data and read data. Two of these locations read back the raw sources and the gated requests. The other two are write-one-to-set and write-one-to-clear ports for the enable mask.

Because the mask has separate set and clear ports, software can turn one source on or off in a single write. It does not need to read the mask first, so there is no read-modify-write hazard. A system builds two copies of the block. One copy has a single slice on bit 0 and serves as the fast-interrupt controller. The other copy has a wider, parameter-chosen width and serves as the normal interrupt controller.

Top module: `setclr_irq_ctrl`

## Requirements
- R1: Reading offset 0x0 (address bits 3:2 = 0) returns the raw source inputs in bits NUM_SRC-1:0, independent of the enable mask.
- R2: After reset the enable mask is all zeros, the request status reads 0 for any sources, and the interrupt output is high.
- R3: Reading offset 0x4 (address bits 3:2 = 1) returns, in bit i, source i ANDed with enable bit i.
- R4: A write to offset 0x8 (address bits 3:2 = 2) sets every enable bit whose write-data bit is 1 and leaves all other enable bits unchanged.
- R5: A write to offset 0xC (address bits 3:2 = 3) clears every enable bit whose write-data bit is 1 and leaves all other enable bits unchanged.
- R6: The interrupt output is registered. One clock after the sources and mask are sampled, it is low exactly when at least one request status bit is 1.
- R7: Writes to offsets 0x0 and 0x4 leave the enable mask unchanged.
- R8: Reading offset 0x8 or 0xC returns the current enable mask. On every read, data bits at or above NUM_SRC are 0. Write-data bits at or above NUM_SRC have no effect.
- R9: An instance with NUM_SRC = 1 behaves as above using bit 0 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Active-high interrupt sources |
| addr_i | input | ADDR_W | Byte address; bits 3:2 select the location |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data for the addressed location (combinational) |
| irq_n_o | output | 1 | Registered active-low interrupt request |

## Verification
The bench sweeps every pairing of a 4-bit mask with a 4-bit source pattern. A design that swaps set and clear, or rewrites untouched mask bits, returns a wrong request status somewhere in that sweep. A design that gates the source status readback with the mask also fails this sweep. It also writes all-ones to the read-only locations and to bits above the slice count. A design that decodes those writes into the mask, or leaks upper data bits, shows a changed mask on readback. The interrupt line is sampled exactly one clock after each new pattern, which exposes an inverted polarity or a missing or extra register stage. The same checks are repeated on a one-slice instance to catch errors that only appear at width 1.

// File: rtl/setclr_irq_pkg.sv
package setclr_irq_pkg;

   // Location select, taken from byte address bits 3:2
   typedef enum logic [1:0] {
      LOC_SRC_STAT = 2'd0,
      LOC_REQ_STAT = 2'd1,
      LOC_EN_SET   = 2'd2,
      LOC_EN_CLR   = 2'd3
   } irq_loc_e;

   localparam int unsigned LOC_LSB = 2;
   localparam int unsigned LOC_MSB = 3;

endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               set_we,
   input  logic               clr_we,
   input  logic [NUM_SRC-1:0] wbits,
   output logic [NUM_SRC-1:0] mask_o
);

   generate
      if (NUM_SRC < 1) begin : g_bad_width
         $error("irq_mask_bank: NUM_SRC must be at least 1");
      end
   endgenerate

   // One storage flop per slice; set and clear never coincide (decoded apart)
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_slice
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               en_q <= 1'b0;
            end else if (set_we && wbits[i]) begin
               en_q <= 1'b1;
            end else if (clr_we && wbits[i]) begin
               en_q <= 1'b0;
            end
         end
         assign mask_o[i] = en_q;
      end
   endgenerate

   // R4: marked bits become 1, unmarked bits keep their value
   p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_we |=> ((mask_o & $past(wbits)) == $past(wbits)) &&
                 ((mask_o & ~$past(wbits)) == ($past(mask_o) & ~$past(wbits))));

   // R5: marked bits become 0, unmarked bits keep their value
   p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_we |=> ((mask_o & $past(wbits)) == '0) &&
                 ((mask_o & ~$past(wbits)) == ($past(mask_o) & ~$past(wbits))));

   // R7: without a mask write the mask holds
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_we || clr_we) |=> mask_o == $past(mask_o));

endmodule

// File: rtl/irq_reg_read.sv
module irq_reg_read
   import setclr_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned DATA_W  = 32
) (
   input  irq_loc_e           loc,
   input  logic [NUM_SRC-1:0] src,
   input  logic [NUM_SRC-1:0] req,
   input  logic [NUM_SRC-1:0] mask,
   output logic [DATA_W-1:0]  rdata_o
);

   generate
      if (NUM_SRC > DATA_W) begin : g_bad_width
         $error("irq_reg_read: NUM_SRC must not exceed DATA_W");
      end
   endgenerate

   logic [NUM_SRC-1:0] pick;

   always_comb begin
      unique case (loc)
         LOC_SRC_STAT: pick = src;
         LOC_REQ_STAT: pick = req;
         default:      pick = mask;
      endcase
   end

   // Zero-extend; a full-width instance needs no padding
   generate
      if (NUM_SRC == DATA_W) begin : g_full
         assign rdata_o = pick;
      end else begin : g_pad
         assign rdata_o = {{(DATA_W - NUM_SRC){1'b0}}, pick};
      end
   endgenerate

endmodule

// File: rtl/irq_line_merge.sv
module irq_line_merge #(
   parameter int unsigned NUM_SRC = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   output logic               irq_n_o
);

   logic any_req;

   // A single slice needs no reduction
   generate
      if (NUM_SRC == 1) begin : g_single
         assign any_req = req_i[0];
      end else begin : g_multi
         assign any_req = |req_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_n_o <= 1'b1;
      end else begin
         irq_n_o <= ~any_req;
      end
   end

endmodule

// File: rtl/setclr_irq_ctrl.sv
module setclr_irq_ctrl
   import setclr_irq_pkg::*;
#(
   parameter int unsigned NUM_SRC = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               wr_en_i,
   input  logic [DATA_W-1:0]  wdata_i,
   output logic [DATA_W-1:0]  rdata_o,
   output logic               irq_n_o
);

   generate
      if (ADDR_W <= LOC_MSB) begin : g_bad_addr
         $error("setclr_irq_ctrl: ADDR_W must be at least 4");
      end
      if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
         $error("setclr_irq_ctrl: NUM_SRC must be in 1..DATA_W");
      end
   endgenerate

   irq_loc_e           loc;
   logic               set_we;
   logic               clr_we;
   logic [NUM_SRC-1:0] mask;
   logic [NUM_SRC-1:0] req;

   assign loc    = irq_loc_e'(addr_i[LOC_MSB:LOC_LSB]);
   assign set_we = wr_en_i && (loc == LOC_EN_SET);
   assign clr_we = wr_en_i && (loc == LOC_EN_CLR);

   // Per-slice gating of source by enable
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_gate
         assign req[i] = src_i[i] & mask[i];
      end
   endgenerate

   irq_mask_bank #(.NUM_SRC(NUM_SRC)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (set_we),
      .clr_we (clr_we),
      .wbits  (wdata_i[NUM_SRC-1:0]),
      .mask_o (mask)
   );

   irq_reg_read #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) u_read (
      .loc     (loc),
      .src     (src_i),
      .req     (req),
      .mask    (mask),
      .rdata_o (rdata_o)
   );

   irq_line_merge #(.NUM_SRC(NUM_SRC)) u_merge (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (req),
      .irq_n_o (irq_n_o)
   );

   // R6: line follows the sampled sources and mask one clock later
   p_line_r6: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> irq_n_o == ~|($past(src_i) & $past(mask)));

   // R6: no active source can produce a request
   p_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i == '0) |=> irq_n_o);

   // R7: writes to read-only locations never reach the mask
   p_ro_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && (loc == LOC_SRC_STAT || loc == LOC_REQ_STAT)) |=> $stable(mask));

endmodule

// File: tb/setclr_irq_ctrl_test.sv
module setclr_irq_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int NSRC = 4;
   localparam int DW   = 32;
   localparam int AW   = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;

   logic [NSRC-1:0] src = '0;
   logic [AW-1:0]   addr = '0;
   logic            wr = 1'b0;
   logic [DW-1:0]   wdata = '0;
   logic [DW-1:0]   rdata;
   logic            irq_n;

   logic            f_src = 1'b0;
   logic [AW-1:0]   f_addr = '0;
   logic            f_wr = 1'b0;
   logic [DW-1:0]   f_wdata = '0;
   logic [DW-1:0]   f_rdata;
   logic            f_irq_n;

   int errors = 0;
   int checks = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   setclr_irq_ctrl #(.NUM_SRC(NSRC), .DATA_W(DW), .ADDR_W(AW)) uut (
      .clk(clk), .rst_n(rst_n), .src_i(src), .addr_i(addr), .wr_en_i(wr),
      .wdata_i(wdata), .rdata_o(rdata), .irq_n_o(irq_n));

   setclr_irq_ctrl #(.NUM_SRC(1), .DATA_W(DW), .ADDR_W(AW)) uut_fast (
      .clk(clk), .rst_n(rst_n), .src_i(f_src), .addr_i(f_addr), .wr_en_i(f_wr),
      .wdata_i(f_wdata), .rdata_o(f_rdata), .irq_n_o(f_irq_n));

   task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr_main(input logic [AW-1:0] a, input logic [DW-1:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic rd_main(input logic [AW-1:0] a, output logic [DW-1:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wr_fast(input logic [AW-1:0] a, input logic [DW-1:0] d);
      f_addr = a; f_wdata = d; f_wr = 1'b1;
      @(negedge clk);
      f_wr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      logic [DW-1:0] d;
      logic [NSRC-1:0] expm;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: reset state
      src = '1;
      rd_main(4'h8, d); check("R2 mask", d, 0);
      rd_main(4'h4, d); check("R2 req", d, 0);
      @(negedge clk);
      check("R2 irq", {31'd0, irq_n}, 1);
      check("R2 fast irq", {31'd0, f_irq_n}, 1);

      // R1 R3 R4 R5 R6: full sweep of mask x sources
      for (int m = 0; m < 16; m++) begin
         for (int s = 0; s < 16; s++) begin
            wr_main(4'hC, 32'hF);          // R5 clear all
            wr_main(4'h8, m);              // R4 set pattern
            src = s[NSRC-1:0];
            rd_main(4'h8, d); check("R4 mask readback", d, m);
            rd_main(4'h0, d); check("R1 raw src", d, s);
            rd_main(4'h4, d); check("R3 req", d, m & s);
            @(negedge clk);
            check("R6 irq", {31'd0, irq_n}, ((m & s) != 0) ? 0 : 1);
         end
      end

      // R4 R5: partial set and clear keep other bits
      wr_main(4'hC, 32'hF);
      wr_main(4'h8, 32'h5);
      wr_main(4'h8, 32'h2);
      rd_main(4'hC, d); check("R4 partial set", d, 32'h7);
      wr_main(4'hC, 32'h4);
      rd_main(4'hC, d); check("R5 partial clear", d, 32'h3);
      wr_main(4'hC, 32'h0);
      rd_main(4'hC, d); check("R5 zero clear", d, 32'h3);

      // R7: writes to read-only locations ignored
      expm = 4'h3;
      wr_main(4'h0, 32'hFFFF_FFFF);
      wr_main(4'h4, 32'hFFFF_FFFF);
      rd_main(4'h8, d); check("R7 mask after ro writes", d, expm);
      wr_main(4'h0, 32'h0);
      wr_main(4'h4, 32'h0);
      rd_main(4'h8, d); check("R7 mask after ro zero writes", d, expm);

      // R8: upper write bits ignored, upper read bits zero
      wr_main(4'hC, 32'hF);
      wr_main(4'h8, 32'hFFFF_FFF0);
      rd_main(4'h8, d); check("R8 upper set ignored", d, 0);
      wr_main(4'h8, 32'hFFFF_FFFF);
      rd_main(4'hC, d); check("R8 mask upper zero", d, 32'hF);
      wr_main(4'hC, 32'hFFFF_FFF0);
      rd_main(4'h8, d); check("R8 upper clear ignored", d, 32'hF);
      src = '1;
      rd_main(4'h0, d); check("R8 src upper zero", d, 32'hF);

      // R9: single-slice instance
      f_src = 1'b1;
      f_addr = 4'h8; #1; check("R9 fast mask reset", f_rdata, 0);
      wr_fast(4'h8, 32'h2);
      f_addr = 4'h8; #1; check("R9 fast upper ignored", f_rdata, 0);
      wr_fast(4'h8, 32'h1);
      f_addr = 4'h4; #1; check("R9 fast req", f_rdata, 1);
      @(negedge clk);
      check("R9 fast irq low", {31'd0, f_irq_n}, 0);
      f_src = 1'b0;
      f_addr = 4'h0; #1; check("R9 fast raw", f_rdata, 0);
      @(negedge clk);
      check("R9 fast irq high", {31'd0, f_irq_n}, 1);
      f_src = 1'b1;
      wr_fast(4'h0, 32'h0);
      wr_fast(4'hC, 32'h1);
      f_addr = 4'h8; #1; check("R9 fast clear", f_rdata, 0);
      @(negedge clk);
      check("R9 fast irq masked", {31'd0, f_irq_n}, 1);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule